// File: doc/BRIEF.md
# Synchronous Serial Port with Ready Handshake

This block moves one byte at a time over a clocked serial link. The byte goes out least-significant bit first while a byte comes in from the partner. A write from the processor side loads the transmit byte. From that point the ready output tells the partner that the port is waiting to exchange data. In internal-clock mode the port makes the serial clock itself, with a half period of 2, 4, 8 up to 256 system clocks selected by a 3-bit field. In this mode it can start on its own, or it can wait until the partner's ready input has held steady long enough to count as real. In external-clock mode the partner supplies the clock. The port starts, and raises its busy output, only once it holds data and sees the partner ready.

A single polarity bit flips the ready output, the ready input and the busy output together, so the port can face a partner that uses active-low handshake lines. A status flag shows that a byte is in progress, and a one-cycle done pulse marks the end of each byte. Clearing the enable bit returns the port to its idle state.

Top module: `ssp_port`

## Requirements
- R1: While cfg_enable is 0 the port is held idle: srdy_out and sbusy_out sit at their inactive level, xfer_flag is 0, sclk_out is 1, and wr_en has no effect.
- R2: With cfg_enable at 1 and no byte in progress, a wr_en pulse loads wr_data, and srdy_out is at its active level in the next cycle.
- R3: srdy_out returns to its inactive level in the same cycle that xfer_flag rises. In internal-clock mode this is the first cycle in which sclk_out is low.
- R4: cfg_low_act = 0 makes srdy_out, srdy_in and sbusy_out active-high. cfg_low_act = 1 makes all three active-low.
- R5: In internal-clock mode sclk_out idles at 1 and gives exactly 8 low phases per byte. Each low phase and each high phase lasts 2^(cfg_div_sel+1) system clocks.
- R6: sout changes only when the serial clock falls, and carries wr_data bit 0 first through bit 7 last. sin is sampled when the serial clock rises. The first sampled bit lands in rd_data bit 0, and rd_data is updated when the byte completes.
- R7: With cfg_wait_rdy = 1 in internal-clock mode, a byte starts only after the synchronized ready input has been seen active at 3 consecutive half-period ticks. A pulse of one half period never starts a byte, and no byte starts within 2 half periods of the ready input going active.
- R8: Taking the ready input inactive during a byte does not cut it short: all 8 bits are still clocked.
- R9: In external-clock mode a byte starts only when a write is pending and the synchronized ready input is active. sbusy_out is at its active level for the whole byte.
- R10: xfer_flag is 1 from the start of a byte to its completion, which is 15 half periods in internal-clock mode. done pulses for exactly one cycle as xfer_flag falls.
- R11: A wr_en pulse while a byte is in progress is ignored: it changes neither the byte on sout nor srdy_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | 0 holds the port idle, 1 lets it run |
| cfg_ext_clk | input | 1 | 1 selects the partner's clock on sclk_in |
| cfg_wait_rdy | input | 1 | Internal mode: 1 makes a byte wait for the qualified ready input |
| cfg_low_act | input | 1 | 1 makes the handshake lines active-low |
| cfg_div_sel | input | 3 | Half period of the internal serial clock, 2^(n+1) system clocks |
| wr_en | input | 1 | Load strobe for the transmit byte |
| wr_data | input | 8 | Transmit byte |
| rd_data | output | 8 | Last received byte |
| xfer_flag | output | 1 | 1 while a byte is in progress |
| done | output | 1 | One-cycle pulse at the end of a byte |
| sclk_in | input | 1 | Serial clock from the partner (external mode) |
| sclk_out | output | 1 | Generated serial clock (internal mode), idles high |
| sout | output | 1 | Serial data out |
| sin | input | 1 | Serial data in |
| srdy_in | input | 1 | Ready line from the partner |
| srdy_out | output | 1 | Ready line to the partner |
| sbusy_out | output | 1 | Busy line, active while a byte is in progress |

## Verification
A wrong state in this block shows up at the pins within one half period of the serial clock. A lost pending flag leaves srdy_out at the wrong level on the very next cycle. A slipped bit counter gives 7 or 9 low phases on sclk_out and a rotated byte in rd_data once done pulses. A qualification counter that counts too early starts the clock within 2 half periods of a ready edge, and the bench watches exactly that window. For each byte the bench counts the flag cycles and the low-clock cycles and compares them with 15 and 8 half periods, so an off-by-one in the tick divider is caught on the first byte.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned CNT_W  = $clog2(BYTE_W);
    localparam int unsigned SEL_W  = 3;
    localparam int unsigned HALF_W = (1 << SEL_W) + 1;
    localparam int unsigned QUAL_N = 3;

    typedef enum logic {
        XS_IDLE = 1'b0,
        XS_RUN  = 1'b1
    } xfer_state_e;

    typedef struct packed {
        logic             enable;
        logic             ext_clk;
        logic             wait_rdy;
        logic             low_act;
        logic [SEL_W-1:0] div_sel;
    } port_cfg_t;

    // half period of the internal serial clock in system clocks
    function automatic logic [HALF_W-1:0] half_period(input logic [SEL_W-1:0] sel);
        return HALF_W'(2) << sel;
    endfunction
endpackage

// File: rtl/ssp_sync.sv
module ssp_sync #(
    parameter int unsigned  W       = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/ssp_tickgen.sv
module ssp_tickgen
    import ssp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [SEL_W-1:0] div_sel,
    output logic             tick
);
    logic [HALF_W-1:0] cnt;
    logic [HALF_W-1:0] reload;

    assign reload = half_period(div_sel) - HALF_W'(1);

    always_ff @(posedge clk) begin
        if (rst || !en)          cnt <= reload;
        else if (cnt == '0)      cnt <= reload;
        else                     cnt <= cnt - HALF_W'(1);
    end

    assign tick = en && (cnt == '0);

    // R5
    tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
endmodule

// File: rtl/ssp_qual.sv
module ssp_qual
    import ssp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic tick,
    input  logic level,
    output logic qualified
);
    localparam int unsigned QW = $clog2(QUAL_N + 1);
    logic [QW-1:0] run_len;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            run_len <= '0;
        end else if (tick) begin
            if (!level)                        run_len <= '0;
            else if (run_len != QW'(QUAL_N))   run_len <= run_len + QW'(1);
        end
    end

    assign qualified = (run_len == QW'(QUAL_N));

    // R7
    qual_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(qualified) |-> ($past(tick) && $past(level)));
endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter
    import ssp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_data,
    input  logic              fall,
    input  logic              rise,
    input  logic              sin,
    output logic              sout,
    output logic [BYTE_W-1:0] rx_data,
    output logic              last_rise
);
    logic [BYTE_W-1:0] sr;
    logic [CNT_W-1:0]  bitcnt;

    assign last_rise = rise && (bitcnt == CNT_W'(BYTE_W - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            sr      <= '0;
            bitcnt  <= '0;
            sout    <= 1'b1;
            rx_data <= '0;
        end else if (load) begin
            sr     <= load_data;
            bitcnt <= '0;
        end else begin
            if (fall) sout <= sr[0];
            if (rise) begin
                sr     <= {sin, sr[BYTE_W-1:1]};
                bitcnt <= bitcnt + CNT_W'(1);
                if (last_rise) rx_data <= {sin, sr[BYTE_W-1:1]};
            end
        end
    end

    // R6
    sout_rise_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (rise && !load) |=> $stable(sout));
endmodule

// File: rtl/ssp_port.sv
module ssp_port
    import ssp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_enable,
    input  logic              cfg_ext_clk,
    input  logic              cfg_wait_rdy,
    input  logic              cfg_low_act,
    input  logic [SEL_W-1:0]  cfg_div_sel,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_data,
    output logic              xfer_flag,
    output logic              done,
    input  logic              sclk_in,
    output logic              sclk_out,
    output logic              sout,
    input  logic              sin,
    input  logic              srdy_in,
    output logic              srdy_out,
    output logic              sbusy_out
);
    port_cfg_t   cfg;
    xfer_state_e st;
    logic        pending, sclk_q, done_q, line_prev;
    logic [1:0]  pin_s;
    logic        line_clk, rdy_act, int_mode, ext_mode, idle, running;
    logic        tick, qualified, go_int, go_ext, start;
    logic        fall_ev, rise_ev, wr_take, finish;

    assign cfg = '{enable: cfg_enable, ext_clk: cfg_ext_clk, wait_rdy: cfg_wait_rdy,
                   low_act: cfg_low_act, div_sel: cfg_div_sel};

    ssp_sync #(.W(2), .RST_VAL(2'b10)) u_sync (
        .clk(clk), .rst(rst), .d({sclk_in, srdy_in}), .q(pin_s)
    );

    assign line_clk = pin_s[1];
    assign rdy_act  = pin_s[0] ^ cfg.low_act;
    assign int_mode = cfg.enable && !cfg.ext_clk;
    assign ext_mode = cfg.enable &&  cfg.ext_clk;
    assign idle     = (st == XS_IDLE);
    assign running  = (st == XS_RUN);

    ssp_tickgen u_tick (
        .clk(clk), .rst(rst), .en(int_mode), .div_sel(cfg.div_sel), .tick(tick)
    );

    ssp_qual u_qual (
        .clk(clk), .rst(rst), .clear(!int_mode || !cfg.wait_rdy),
        .tick(tick), .level(rdy_act), .qualified(qualified)
    );

    assign go_int  = int_mode && idle && pending && tick && (!cfg.wait_rdy || qualified);
    assign go_ext  = ext_mode && idle && pending && rdy_act;
    assign start   = go_int || go_ext;
    assign fall_ev = go_int
                   || (int_mode && running && tick && sclk_q)
                   || (ext_mode && running && line_prev && !line_clk);
    assign rise_ev = (int_mode && running && tick && !sclk_q)
                   || (ext_mode && running && !line_prev && line_clk);
    assign wr_take = cfg.enable && wr_en && idle && !start;

    ssp_shifter u_shift (
        .clk(clk), .rst(rst), .load(wr_take), .load_data(wr_data),
        .fall(fall_ev), .rise(rise_ev), .sin(sin),
        .sout(sout), .rx_data(rd_data), .last_rise(finish)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= XS_IDLE;
            pending   <= 1'b0;
            sclk_q    <= 1'b1;
            done_q    <= 1'b0;
            line_prev <= 1'b1;
        end else begin
            line_prev <= line_clk;
            done_q    <= finish;
            if (!cfg.enable) begin
                st      <= XS_IDLE;
                pending <= 1'b0;
                sclk_q  <= 1'b1;
            end else begin
                if (wr_take) pending <= 1'b1;
                if (start) begin
                    pending <= 1'b0;
                    st      <= XS_RUN;
                end
                if (int_mode && fall_ev) sclk_q <= 1'b0;
                if (int_mode && rise_ev) sclk_q <= 1'b1;
                if (finish) st <= XS_IDLE;
            end
        end
    end

    assign sclk_out  = sclk_q;
    assign srdy_out  = pending ^ cfg.low_act;
    assign sbusy_out = running ^ cfg.low_act;
    assign xfer_flag = running;
    assign done      = done_q;

    // R1
    init_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_enable |=> (xfer_flag == 1'b0 && sclk_out == 1'b1));
    // R3
    start_clears_ready_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(xfer_flag) |-> (srdy_out == cfg_low_act));
    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R10
    done_after_run_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(xfer_flag) && !xfer_flag));
    // R11
    write_in_run_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer_flag && wr_en) |=> (srdy_out == cfg_low_act));
endmodule

// File: tb/ssp_port_tb.sv
module ssp_port_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_enable = 1'b0, cfg_ext_clk = 1'b0, cfg_wait_rdy = 1'b0, cfg_low_act = 1'b0;
    logic [2:0] cfg_div_sel = 3'd0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       xfer_flag, done, sclk_out, sout, srdy_out, sbusy_out;
    logic       sclk_in = 1'b1, srdy_in = 1'b0;
    logic       sin;

    int n_chk = 0, n_fail = 0;
    int fall_total = 0, base = 0, done_cnt = 0;
    logic [7:0] p_byte = 8'h00;
    logic [7:0] cap = 8'h00;
    logic       lclk;

    always #4 clk = ~clk;

    ssp_port u_dut (
        .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_ext_clk(cfg_ext_clk),
        .cfg_wait_rdy(cfg_wait_rdy), .cfg_low_act(cfg_low_act), .cfg_div_sel(cfg_div_sel),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .xfer_flag(xfer_flag),
        .done(done), .sclk_in(sclk_in), .sclk_out(sclk_out), .sout(sout), .sin(sin),
        .srdy_in(srdy_in), .srdy_out(srdy_out), .sbusy_out(sbusy_out)
    );

    // partner model: capture on rising line clock, present next bit after each fall
    assign lclk = cfg_ext_clk ? sclk_in : sclk_out;
    always @(posedge lclk) cap <= {sout, cap[7:1]};
    always @(negedge lclk) fall_total <= fall_total + 1;
    always @(posedge clk) if (done) done_cnt <= done_cnt + 1;

    int bidx;
    always_comb begin
        bidx = fall_total - base;
        if (bidx < 1) bidx = 0;
        else if (bidx > 8) bidx = 7;
        else bidx = bidx - 1;
        sin = p_byte[bidx[2:0]];
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic write_byte(input logic [7:0] d);
        @(negedge clk);
        wr_data = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_done(output int fc, output int lc, output int seen, output int rdy_at_start);
        int first;
        fc = 0; lc = 0; seen = 0; rdy_at_start = -1; first = 1;
        for (int k = 0; k < 20000; k++) begin
            @(negedge clk);
            if (xfer_flag) begin
                fc++;
                if (first) begin
                    rdy_at_start = int'(srdy_out);
                    first = 0;
                end
            end
            if (!sclk_out) lc++;
            if (done) begin
                seen = 1;
                break;
            end
        end
    endtask

    task automatic run_int(input logic [7:0] d, input logic [7:0] p, input int sel, input logic pol);
        int fc, lc, seen, rs, h;
        h = 2 << sel;
        @(negedge clk);
        cfg_ext_clk = 1'b0; cfg_wait_rdy = 1'b0; cfg_low_act = pol; cfg_div_sel = 3'(sel);
        p_byte = p; base = fall_total;
        write_byte(d);
        check("R2", "srdy_out active after write", int'(srdy_out), int'(!pol));
        wait_done(fc, lc, seen, rs);
        check("R10", "done pulse seen", seen, 1);
        check("R10", "flag cycles", fc, 15 * h);
        check("R5", "sclk low cycles", lc, 8 * h);
        check("R3", "srdy_out inactive at start", rs, int'(pol));
        check("R6", "bits seen on sout", int'(cap), int'(d));
        check("R6", "rd_data", int'(rd_data), int'(p));
        check("R4", "srdy_out idle level", int'(srdy_out), int'(pol));
        check("R4", "sbusy_out idle level", int'(sbusy_out), int'(pol));
        check("R5", "sclk_out idles high", int'(sclk_out), 1);
    endtask

    task automatic run_ext(input logic [7:0] d, input logic [7:0] p, input logic pol);
        int dc;
        @(negedge clk);
        cfg_ext_clk = 1'b1; cfg_wait_rdy = 1'b0; cfg_low_act = pol; srdy_in = pol;
        p_byte = p; base = fall_total;
        write_byte(d);
        repeat (10) @(negedge clk);
        check("R9", "no start without ready", int'(xfer_flag), 0);
        check("R9", "busy inactive without ready", int'(sbusy_out), int'(pol));
        check("R2", "srdy_out active while pending", int'(srdy_out), int'(!pol));
        srdy_in = !pol;
        repeat (5) @(negedge clk);
        check("R9", "start with ready and data", int'(xfer_flag), 1);
        check("R9", "busy active in byte", int'(sbusy_out), int'(!pol));
        check("R3", "srdy_out inactive at start", int'(srdy_out), int'(pol));
        dc = done_cnt;
        for (int b = 0; b < 8; b++) begin
            sclk_in = 1'b0;
            repeat (6) @(negedge clk);
            sclk_in = 1'b1;
            repeat (6) @(negedge clk);
        end
        check("R10", "one done pulse", done_cnt - dc, 1);
        check("R10", "flag clear after byte", int'(xfer_flag), 0);
        check("R9", "busy inactive after byte", int'(sbusy_out), int'(pol));
        check("R6", "ext bits on sout", int'(cap), int'(d));
        check("R6", "ext rd_data", int'(rd_data), int'(p));
        srdy_in = pol;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int fc, lc, seen, rs;
        logic [7:0] pats [4] = '{8'h01, 8'h80, 8'hA5, 8'h3C};
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1", "srdy_out after reset", int'(srdy_out), 0);
        check("R1", "sbusy_out after reset", int'(sbusy_out), 0);
        check("R1", "flag after reset", int'(xfer_flag), 0);
        check("R1", "sclk_out after reset", int'(sclk_out), 1);
        write_byte(8'h77);
        repeat (50) @(negedge clk);
        check("R1", "write ignored while disabled", int'(srdy_out), 0);
        check("R1", "no byte while disabled", int'(xfer_flag), 0);
        cfg_enable = 1'b1;
        repeat (20) @(negedge clk);
        check("R1", "no stale byte after enable", int'(xfer_flag), 0);
        cfg_low_act = 1'b1;
        @(negedge clk);
        check("R4", "inverted srdy_out idle", int'(srdy_out), 1);
        check("R4", "inverted sbusy_out idle", int'(sbusy_out), 1);

        // internal-clock sweep
        for (int pol = 0; pol < 2; pol++)
            for (int sel = 0; sel < 3; sel++)
                for (int i = 0; i < 4; i++)
                    run_int(pats[i], ~pats[i] ^ 8'(sel * 17), sel, logic'(pol));
        run_int(8'h96, 8'h5B, 3, 1'b0);

        // R7 qualification of the ready input
        @(negedge clk);
        cfg_low_act = 1'b0; cfg_wait_rdy = 1'b1; cfg_div_sel = 3'd1; srdy_in = 1'b0;
        p_byte = 8'hE1; base = fall_total;
        write_byte(8'h5A);
        repeat (40) @(negedge clk);
        check("R7", "no start without ready", int'(xfer_flag), 0);
        srdy_in = 1'b1;
        repeat (4) @(negedge clk);
        srdy_in = 1'b0;
        repeat (40) @(negedge clk);
        check("R7", "short ready pulse ignored", int'(xfer_flag), 0);
        srdy_in = 1'b1;
        repeat (8) @(negedge clk);
        check("R7", "no start within 2 half periods", int'(xfer_flag), 0);
        wait_done(fc, lc, seen, rs);
        check("R7", "start after qualified ready", seen, 1);
        check("R7", "qualified byte out", int'(cap), 8'h5A);
        check("R7", "qualified byte in", int'(rd_data), 8'hE1);
        srdy_in = 1'b0;

        // R8 drop ready mid-byte, active-low input
        @(negedge clk);
        cfg_low_act = 1'b1; cfg_div_sel = 3'd2; srdy_in = 1'b1;
        p_byte = 8'h4D; base = fall_total;
        write_byte(8'hB2);
        srdy_in = 1'b0;
        fork
            wait_done(fc, lc, seen, rs);
            begin
                while (!xfer_flag) @(negedge clk);
                @(negedge clk);
                srdy_in = 1'b1;
            end
        join
        check("R8", "byte completes after ready drop", seen, 1);
        check("R8", "all 8 clocks after ready drop", lc, 8 * 8);
        check("R8", "full byte out", int'(cap), 8'hB2);
        check("R4", "active-low ready input started byte", int'(rd_data), 8'h4D);

        // R11 write during byte ignored
        @(negedge clk);
        cfg_low_act = 1'b0; cfg_wait_rdy = 1'b0; cfg_div_sel = 3'd1;
        p_byte = 8'h18; base = fall_total;
        write_byte(8'hC3);
        fork
            wait_done(fc, lc, seen, rs);
            begin
                while (!xfer_flag) @(negedge clk);
                @(negedge clk);
                wr_data = 8'hFF;
                wr_en = 1'b1;
                @(negedge clk);
                wr_en = 1'b0;
                check("R11", "srdy_out after ignored write", int'(srdy_out), 0);
            end
        join
        check("R11", "byte unchanged by write", int'(cap), 8'hC3);
        repeat (40) @(negedge clk);
        check("R11", "no second byte", int'(xfer_flag), 0);
        check("R11", "srdy_out stays inactive", int'(srdy_out), 0);

        // external-clock mode
        @(negedge clk);
        cfg_ext_clk = 1'b1; srdy_in = 1'b1;
        repeat (10) @(negedge clk);
        check("R9", "ready without data no start", int'(xfer_flag), 0);
        srdy_in = 1'b0;
        run_ext(8'h6E, 8'h91, 1'b0);
        run_ext(8'h0F, 8'hF0, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule